// File: doc/BRIEF.md
# Vertical Scan Counter with Split-Screen Address Restart

This block is the vertical half of a raster display timing engine. Each `line_end` pulse from the horizontal section moves a scanline counter forward by one. The counter wraps at a programmable frame length. On each line change, the block also produces the display-memory word address at which fetching of the new line begins. Above a programmable compare line, the address runs from a programmable start address. On the compare line it restarts at zero, and it runs on from zero below that line. This lets the top and bottom parts of the screen show different regions of the frame buffer.

The frame length comes from register fields that sit in several places, and a mode bit decides which fields are used. A narrow mode forms a 10-bit total from a low byte plus two bits of a shared overflow byte. A wide mode forms a 12-bit total from the low byte plus a 4-bit extension nibble. The block has a byte-wide write port. Writes collect in a pending copy, and the whole copy takes effect together on the line-end that wraps the frame, so no frame ever mixes settings. The outputs are plain status pins paced by `line_end`. There is no stream interface and therefore no back-pressure: every pulse is consumed in the cycle it arrives.

Top module: `vscan_split_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `scan_line` is 0, `line_addr` is 0 and `frame_start` is 0. All settings are zero until written.
- R2: A clock edge with `line_end` high and `scan_line` below the last line raises `scan_line` by one. Without `line_end`, `scan_line` and `line_addr` hold their values.
- R3: With programmed total T, the last line is T+1, so a frame has T+2 lines. A `line_end` on line T+1 returns `scan_line` to 0, and `frame_start` is high for exactly the next cycle.
- R4: The frame-length mode is bit 0 of the byte at select 8. When it is 0, T = {overflow bit 5, overflow bit 0, low byte}. The low byte is at select 0 and the overflow byte is at select 1.
- R5: When the mode bit is 1, T = {extension bits 3..0, low byte}, with the extension at select 7. In this mode, overflow bits 0 and 5 have no effect.
- R6: The compare line C = {max-scan byte bit 6, overflow bit 4, compare low byte}. The max-scan byte is at select 2 and the compare low byte is at select 5.
- R7: On line 0 of a frame, `line_addr` = {start high byte (select 3), start low byte (select 4)}, unless C is 0.
- R8: On every other line that is not C, `line_addr` = previous `line_addr` + pitch byte (select 6), modulo 2^16.
- R9: On the line equal to C, `line_addr` is 0. The lines after it continue from 0 by the same pitch.
- R10: Writes change nothing in the frame that is running. All written values apply together from the next frame's line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the pending settings |
| cfg_wr_sel | input | 4 | Setting select, codes 0 to 8 |
| cfg_wr_data | input | 8 | Write byte |
| line_end | input | 1 | One-cycle pulse at the end of each horizontal line |
| frame_start | output | 1 | High for one cycle after the counter wraps to line 0 |
| scan_line | output | 13 | Current scanline number |
| line_addr | output | 16 | Display-memory start address of the current line |

## Verification
The hardest cases to reach are compare lines and frame lengths above 511. These need both high compare bits set together with a wide-mode frame longer than the compare line. The need to wait for a commit makes them harder still. The stimulus loads the pending settings, lets one whole frame pass so they take effect, and then runs a full frame of about 800 lines with irregular gaps between line pulses. It captures the address on the compare line and on the line after it. A mid-frame rewrite of the total, an address that wraps past 0xFFFF, and a compare value of 0 that coincides with line 0 are each driven the same way.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
  localparam int BYTE_W   = 8;
  localparam int TOT_W    = 12;
  localparam int NARROW_W = 10;
  localparam int EXT_W    = TOT_W - BYTE_W;
  localparam int CMP_W    = 10;
  localparam int CNT_W    = TOT_W + 1;
  localparam int ADDR_W   = 2 * BYTE_W;
  localparam int SEL_W    = 4;

  localparam int OVF_T8_BIT   = 0;
  localparam int OVF_C8_BIT   = 4;
  localparam int OVF_T9_BIT   = 5;
  localparam int MSCAN_C9_BIT = 6;

  typedef enum logic [SEL_W-1:0] {
    SEL_TOT_LO   = 4'd0,
    SEL_OVF      = 4'd1,
    SEL_MAXSCAN  = 4'd2,
    SEL_START_HI = 4'd3,
    SEL_START_LO = 4'd4,
    SEL_CMP_LO   = 4'd5,
    SEL_PITCH    = 4'd6,
    SEL_TOT_EXT  = 4'd7,
    SEL_MODE     = 4'd8
  } vscan_sel_e;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [EXT_W-1:0]  hi;
    logic              t8;
    logic              t9;
    logic              wide;
  } tot_cfg_t;

  typedef struct packed {
    logic              c8;
    logic              c9;
    logic [BYTE_W-1:0] cmp_lo;
    logic [BYTE_W-1:0] start_hi;
    logic [BYTE_W-1:0] start_lo;
    logic [BYTE_W-1:0] pitch;
  } addr_cfg_t;
endpackage

// File: rtl/vscan_cfg_regs.sv
module vscan_cfg_regs
  import vscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              commit,
  output tot_cfg_t          live_tot,
  output addr_cfg_t         next_addr
);
  tot_cfg_t  pend_tot;
  addr_cfg_t pend_addr;
  addr_cfg_t live_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tot  <= '0;
      pend_addr <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_TOT_LO:   pend_tot.lo <= wr_data;
        SEL_TOT_EXT:  pend_tot.hi <= wr_data[EXT_W-1:0];
        SEL_OVF: begin
          pend_tot.t8  <= wr_data[OVF_T8_BIT];
          pend_tot.t9  <= wr_data[OVF_T9_BIT];
          pend_addr.c8 <= wr_data[OVF_C8_BIT];
        end
        SEL_MAXSCAN:  pend_addr.c9       <= wr_data[MSCAN_C9_BIT];
        SEL_START_HI: pend_addr.start_hi <= wr_data;
        SEL_START_LO: pend_addr.start_lo <= wr_data;
        SEL_CMP_LO:   pend_addr.cmp_lo   <= wr_data;
        SEL_PITCH:    pend_addr.pitch    <= wr_data;
        SEL_MODE:     pend_tot.wide      <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_tot  <= '0;
      live_addr <= '0;
    end else if (commit) begin
      live_tot  <= pend_tot;
      live_addr <= pend_addr;
    end
  end

  // The line that follows a wrap already belongs to the new frame.
  assign next_addr = commit ? pend_addr : live_addr;

  // R10: settings in force only move at a frame wrap
  a_r10_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(live_tot) && $stable(live_addr)));
endmodule

// File: rtl/vscan_total_asm.sv
module vscan_total_asm
  import vscan_pkg::*;
(
  input  tot_cfg_t         cfg,
  output logic [TOT_W-1:0] total
);
  always_comb begin
    if (cfg.wide) begin
      total = {cfg.hi, cfg.lo};
    end else begin
      total = {{(TOT_W-NARROW_W){1'b0}}, cfg.t9, cfg.t8, cfg.lo};
    end
  end
endmodule

// File: rtl/vscan_line_ctr.sv
module vscan_line_ctr
  import vscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  logic [TOT_W-1:0] total,
  output logic [CNT_W-1:0] scan,
  output logic             wrap,
  output logic             frame_start
);
  logic [CNT_W-1:0] last_line;

  assign last_line = {1'b0, total} + 1'b1;
  assign wrap      = line_end && (scan == last_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan        <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= wrap;
      if (wrap) begin
        scan <= '0;
      end else if (line_end) begin
        scan <= scan + 1'b1;
      end
    end
  end

  // R2: one step per line pulse
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && scan != last_line) |=> scan == $past(scan) + 1'b1);
  // R2: no pulse, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(scan));
  // R3: the counter never passes the last line
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    scan <= last_line);
  // R3: the frame marker only appears on line 0
  a_r3_marker_line0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> scan == '0);
endmodule

// File: rtl/vscan_addr_gen.sv
module vscan_addr_gen
  import vscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  next_line,
  input  logic [CNT_W-1:0]  cur_line,
  input  addr_cfg_t         cfg,
  output logic [ADDR_W-1:0] addr
);
  logic [CMP_W-1:0]  cmp;
  logic [CNT_W-1:0]  cmp_ext;
  logic [ADDR_W-1:0] start;
  logic [ADDR_W-1:0] pitch;

  assign cmp     = {cfg.c9, cfg.c8, cfg.cmp_lo};
  assign cmp_ext = {{(CNT_W-CMP_W){1'b0}}, cmp};
  assign start   = {cfg.start_hi, cfg.start_lo};
  assign pitch   = {{(ADDR_W-BYTE_W){1'b0}}, cfg.pitch};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (line_end) begin
      if (next_line == cmp_ext) begin
        addr <= '0;
      end else if (wrap) begin
        addr <= start;
      end else begin
        addr <= addr + pitch;
      end
    end
  end

  // R9: the line sitting on the compare value fetches from address 0
  a_r9_split_zero: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (cur_line != cmp_ext) || (addr == '0));
  // R2: address frozen between line pulses
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(addr));
endmodule

// File: rtl/vscan_split_ctrl.sv
module vscan_split_ctrl
  import vscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_wr_sel,
  input  logic [BYTE_W-1:0] cfg_wr_data,
  input  logic              line_end,
  output logic              frame_start,
  output logic [CNT_W-1:0]  scan_line,
  output logic [ADDR_W-1:0] line_addr
);
  tot_cfg_t         live_tot;
  addr_cfg_t        next_addr;
  logic [TOT_W-1:0] total;
  logic             wrap;
  logic [CNT_W-1:0] next_line;

  vscan_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_sel    (cfg_wr_sel),
    .wr_data   (cfg_wr_data),
    .commit    (wrap),
    .live_tot  (live_tot),
    .next_addr (next_addr)
  );

  vscan_total_asm u_total (
    .cfg   (live_tot),
    .total (total)
  );

  vscan_line_ctr u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .total       (total),
    .scan        (scan_line),
    .wrap        (wrap),
    .frame_start (frame_start)
  );

  assign next_line = wrap ? '0 : scan_line + 1'b1;

  vscan_addr_gen u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_end  (line_end),
    .wrap      (wrap),
    .next_line (next_line),
    .cur_line  (scan_line),
    .cfg       (next_addr),
    .addr      (line_addr)
  );

  // R3: frame marker is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: tb/sim_vscan_split_ctrl.sv
`timescale 1ns/1ps
module sim_vscan_split_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_sel = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic        line_end = 1'b0;
  logic        frame_start;
  logic [12:0] scan_line;
  logic [15:0] line_addr;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  vscan_split_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .line_end(line_end), .frame_start(frame_start),
    .scan_line(scan_line), .line_addr(line_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] rp [9];
  logic [7:0] ra [9];
  int m_scan = 0;
  int m_addr = 0;
  bit m_fs   = 0;

  function automatic int f_tot();
    if (ra[8][0]) return int'({ra[7][3:0], ra[0]});
    return int'({ra[1][5], ra[1][0], ra[0]});
  endfunction
  function automatic int f_cmp();
    return int'({ra[2][6], ra[1][4], ra[5]});
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) begin rp[i] = '0; ra[i] = '0; end
      m_scan = 0; m_addr = 0; m_fs = 0;
    end else begin
      m_fs = 0;
      if (line_end) begin
        if (m_scan == f_tot() + 1) begin
          for (int i = 0; i < 9; i++) ra[i] = rp[i];
          m_scan = 0;
          m_fs = 1;
          m_addr = (f_cmp() == 0) ? 0 : int'({ra[3], ra[4]});
        end else begin
          m_scan = m_scan + 1;
          m_addr = (m_scan == f_cmp()) ? 0 : ((m_addr + int'(ra[6])) & 16'hFFFF);
        end
      end
      if (cfg_wr_en && cfg_wr_sel <= 4'd8) rp[cfg_wr_sel] = cfg_wr_data;
    end
  end

  // compared one time unit after every rising edge
  always @(posedge clk) begin
    #1;
    chk(scan_line == 13'(m_scan), (m_scan == 0) ? "R3 line wrap" : "R2 line step",
        int'(scan_line), m_scan);
    chk(frame_start == m_fs, "R3 frame marker", int'(frame_start), int'(m_fs));
    if (m_scan == f_cmp())
      chk(line_addr == 16'(m_addr), "R9 split address", int'(line_addr), m_addr);
    else if (m_scan == 0)
      chk(line_addr == 16'(m_addr), "R7 top address", int'(line_addr), m_addr);
    else
      chk(line_addr == 16'(m_addr), "R8 pitch advance", int'(line_addr), m_addr);
  end

  // ---------------- stimulus helpers ----------------
  int peak = 0;
  int watch = -1;
  int capw = -1, capw1 = -1, cap0 = -1;
  bit got_fs;

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 4'(sel); cfg_wr_data = 8'(data);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic line();
    int gap;
    @(negedge clk);
    line_end = 1'b1;
    @(posedge clk);
    #1;
    got_fs = frame_start;
    if (int'(scan_line) > peak) peak = int'(scan_line);
    if (int'(scan_line) == watch) capw = int'(line_addr);
    if (int'(scan_line) == watch + 1) capw1 = int'(line_addr);
    if (frame_start) cap0 = int'(line_addr);
    @(negedge clk);
    line_end = 1'b0;
    gap = int'($urandom_range(0, 2));
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic next_frame();
    do line(); while (!got_fs);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(scan_line == 0, "R1 reset line", int'(scan_line), 0);
    chk(line_addr == 0, "R1 reset address", int'(line_addr), 0);
    chk(frame_start == 0, "R1 reset marker", int'(frame_start), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(scan_line == 0 && line_addr == 0, "R1 after release", int'(scan_line), 0);

    // narrow mode: total 0x305, compare 255, start 0x1234, pitch 0x50
    wr(8, 8'h00); wr(0, 8'h05); wr(1, 8'h21); wr(2, 8'h00); wr(5, 8'hFF);
    wr(3, 8'h12); wr(4, 8'h34); wr(6, 8'h50);
    next_frame();
    chk(cap0 == 16'h1234, "R7 start address on line 0", cap0, 16'h1234);
    peak = 0; watch = 255;
    next_frame();
    chk(peak == 774, "R4 narrow total frame length", peak, 774);
    chk(capw == 0, "R9 compare line restarts at 0", capw, 0);
    chk(capw1 == 16'h50, "R9 line after compare continues by pitch", capw1, 16'h50);

    // mid-frame rewrite of the total
    peak = 0; watch = -1;
    repeat (10) line();
    wr(0, 8'h00);
    next_frame();
    chk(peak == 774, "R10 running frame keeps old total", peak, 774);
    peak = 0;
    next_frame();
    chk(peak == 769, "R10 new total from next frame", peak, 769);

    // wide mode: total 0x320, overflow total bits set but ignored, compare 773
    wr(8, 8'h01); wr(7, 8'h03); wr(0, 8'h20); wr(1, 8'h31); wr(2, 8'h40); wr(5, 8'h05);
    next_frame();
    peak = 0; watch = 773;
    next_frame();
    chk(peak == 801, "R5 wide total frame length", peak, 801);
    chk(capw == 0, "R6 ten-bit compare above 511", capw, 0);
    chk(capw1 == 16'h50, "R6 continue after high compare", capw1, 16'h50);

    // short frames, compare at line 0, address wrap
    wr(8, 8'h00); wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h08); wr(5, 8'h00);
    wr(3, 8'hFF); wr(4, 8'hF0); wr(6, 8'h20);
    watch = -1;
    next_frame();
    chk(cap0 == 0, "R9 compare 0 overrides start", cap0, 0);
    peak = 0; watch = 1;
    next_frame();
    chk(capw == 16'h20, "R9 pitch from 0 after compare 0", capw, 16'h20);
    chk(peak == 9, "R3 frame of total plus two lines", peak, 9);
    wr(5, 8'hFF);
    next_frame();
    chk(cap0 == 16'hFFF0, "R7 start restored when compare off", cap0, 16'hFFF0);
    next_frame();
    chk(capw == 16'h0010, "R8 address wraps modulo 2^16", capw, 16'h0010);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule